// File: doc/BRIEF.md
# Selectable Two-Stage Strobe Divider

This block turns a free-running reference clock into two timing strobes. The first, the base tick, divides the reference by one of two fixed ratios, 10 or 14. A single select input picks the ratio. The second, the rate tick, divides the base tick by 8, 4, 2 or 1. A two-bit rate code picks that ratio: each step up in the code halves the count. Both strobes are one-cycle enable pulses in the reference domain. They are not generated clocks, so downstream logic runs on the reference clock and qualifies its work with them.

A change to either selection is never applied in the middle of a period. The ratio select is sampled only at the cycle that ends a base period. The rate code is sampled only at the cycle that ends a rate period. A period in progress therefore always finishes at its original length, and no short pulse gap is ever produced. A synchronous reset clears both counters and loads both selections directly.

Top module: `refclk_strobe_div`

## Requirements
- R1: While `rst` is high, `tclk_stb` and `txclk_stb` stay low, and both counters return to zero.
- R2: With the ratio select captured low, consecutive `tclk_stb` pulses are exactly 10 reference cycles apart.
- R3: With the ratio select captured high, consecutive `tclk_stb` pulses are exactly 14 reference cycles apart.
- R4: With rate code 0 captured, `txclk_stb` fires on every 8th `tclk_stb` pulse.
- R5: With rate code 1 captured, `txclk_stb` fires on every 4th `tclk_stb` pulse. With rate code 2 captured, it fires on every 2nd.
- R6: With rate code 3 captured, `txclk_stb` is high on every cycle in which `tclk_stb` is high.
- R7: Each strobe is high for one reference cycle only, and `txclk_stb` is never high when `tclk_stb` is low.
- R8: The `mode_hi` value is captured at the clock edge that ends a `tclk_stb` cycle. The base period that follows uses the captured value, and the period in progress keeps the old ratio.
- R9: The `rate_code` value is captured at the clock edge that ends a `txclk_stb` cycle. The rate period in progress keeps its old count.
- R10: After reset is released, the first `tclk_stb` comes in the N-th cycle with `rst` low, where N is the selected base ratio. The first `txclk_stb` comes on the M-th base tick, where M is the selected rate ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hi | input | 1 | Base ratio select: 0 divides by 10, 1 divides by 14 |
| rate_code | input | 2 | Rate code: 0 gives /8, 1 gives /4, 2 gives /2, 3 gives /1 of the base tick |
| tclk_stb | output | 1 | One-cycle base tick |
| txclk_stb | output | 1 | One-cycle rate tick, always coincident with a base tick |

## Verification
The bench builds the block with its default parameters: ratios of 10 and 14 and a two-bit rate code. Under these values every select/code pairing fits in a short run, and even the longest rate period is only 112 reference cycles. Each of the eight pairings is entered through reset, which covers the first-period timing. A long random phase then toggles the select and the code at arbitrary cycles. Some of those changes land exactly on a boundary cycle and others land mid-period, which exercises the deferred capture in both stages.

// File: rtl/strobe_div_pkg.sv
package strobe_div_pkg;

  // Base-stage ratio for a given select value.
  function automatic int unsigned base_ratio(input logic sel,
                                             input int unsigned lo,
                                             input int unsigned hi);
    return sel ? hi : lo;
  endfunction

  // Rate-stage ratio: halves with each step of the code.
  function automatic int unsigned rate_ratio(input int unsigned code,
                                             input int unsigned max_code);
    return 32'd1 << (max_code - code);
  endfunction

endpackage

// File: rtl/base_tick_gen.sv
module base_tick_gen
  import strobe_div_pkg::*;
#(
  parameter int unsigned DIV_LO = 10,
  parameter int unsigned DIV_HI = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  output logic tick,
  output logic sel_active
);
  localparam int unsigned MAXD = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int unsigned CW   = $clog2(MAXD);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          sel_q;
  logic          wrap;

  always_comb last = CW'(base_ratio(sel_q, DIV_LO, DIV_HI) - 32'd1);
  assign wrap       = !rst && (cnt == last);
  assign tick       = wrap;
  assign sel_active = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= sel_in;
    end else if (wrap) begin
      cnt   <= '0;
      sel_q <= sel_in;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R7
  base_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R8
  base_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sel_active));

  // R2
  base_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

  // R1
  base_reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0));

endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import strobe_div_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic [CODE_W-1:0] code_in,
  output logic              tick,
  output logic [CODE_W-1:0] code_active
);
  localparam int unsigned MAXC = (32'd1 << CODE_W) - 32'd1;
  localparam int unsigned CW   = (MAXC > 0) ? MAXC : 1;

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     last;
  logic [CODE_W-1:0] code_q;
  logic              wrap;

  always_comb last = CW'(rate_ratio(32'(code_q), MAXC) - 32'd1);
  assign wrap        = base_tick && (cnt == last);
  assign tick        = wrap;
  assign code_active = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      code_q <= code_in;
    end else if (base_tick) begin
      if (wrap) begin
        cnt    <= '0;
        code_q <= code_in;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end

  // R9
  rate_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(code_active));

  // R4
  rate_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(cnt));

  // R5
  rate_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

endmodule

// File: rtl/refclk_strobe_div.sv
module refclk_strobe_div #(
  parameter int unsigned DIV_LO = 10,
  parameter int unsigned DIV_HI = 14,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_hi,
  input  logic [CODE_W-1:0] rate_code,
  output logic              tclk_stb,
  output logic              txclk_stb
);
  localparam int unsigned MAXC = (32'd1 << CODE_W) - 32'd1;

  logic              base_tick;
  logic              base_sel;
  logic              rate_tick;
  logic [CODE_W-1:0] rate_code_q;

  base_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_base (
    .clk       (clk),
    .rst       (rst),
    .sel_in    (mode_hi),
    .tick      (base_tick),
    .sel_active(base_sel)
  );

  rate_tick_gen #(.CODE_W(CODE_W)) u_rate (
    .clk        (clk),
    .rst        (rst),
    .base_tick  (base_tick),
    .code_in    (rate_code),
    .tick       (rate_tick),
    .code_active(rate_code_q)
  );

  assign tclk_stb  = base_tick;
  assign txclk_stb = rate_tick;

  // R7
  tx_in_tclk_chk: assert property (@(posedge clk) disable iff (rst)
    txclk_stb |-> tclk_stb);

  // R6
  fastest_code_chk: assert property (@(posedge clk) disable iff (rst)
    (tclk_stb && (rate_code_q == CODE_W'(MAXC))) |-> txclk_stb);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!tclk_stb && !txclk_stb));

  // R8
  base_sel_capture_chk: assert property (@(posedge clk) disable iff (rst)
    tclk_stb |=> (base_sel == $past(mode_hi)));

endmodule

// File: tb/refclk_strobe_div_bench.sv
module refclk_strobe_div_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_hi = 1'b0;
  logic [1:0] rate_code = 2'd0;
  logic       tclk_stb, txclk_stb;

  always #2.5 clk = ~clk;

  refclk_strobe_div u_refclk_strobe_div (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .rate_code(rate_code),
    .tclk_stb(tclk_stb), .txclk_stb(txclk_stb)
  );

  int n_chk = 0, n_fail = 0;
  int cyc, tcount, exp_t, exp_x;
  bit prev_t, first_t, first_x;

  function automatic int exp_base(input logic m);
    if (m) return 14;
    return 10;
  endfunction

  function automatic int exp_sub(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic string base_tag(input int r, input bit chg, input bit first);
    if (first) return "R10";
    if (chg) return "R8";
    return (r == 10) ? "R2" : "R3";
  endfunction

  function automatic string rate_tag(input int r, input bit chg, input bit first);
    if (first) return "R10";
    if (chg) return "R9";
    if (r == 8) return "R4";
    if (r == 1) return "R6";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  bit t_chg = 0, x_chg = 0;

  task automatic observe();
    int nt, nx;
    if (rst) begin
      chk(!tclk_stb && !txclk_stb, "R1", int'({tclk_stb, txclk_stb}), 0);
      return;
    end
    cyc++;
    if (txclk_stb && !tclk_stb) chk(1'b0, "R7", 1, 0);
    if (tclk_stb && prev_t) chk(1'b0, "R7", 2, 1);
    if (!tclk_stb && cyc >= exp_t) chk(1'b0, base_tag(exp_t, t_chg, first_t), cyc, exp_t);
    if (tclk_stb) begin
      chk(cyc == exp_t, base_tag(exp_t, t_chg, first_t), cyc, exp_t);
      cyc = 0;
      first_t = 0;
      nt = exp_base(mode_hi);
      t_chg = (nt != exp_t);
      exp_t = nt;
      tcount++;
      if (txclk_stb) begin
        chk(tcount == exp_x, rate_tag(exp_x, x_chg, first_x), tcount, exp_x);
        tcount = 0;
        first_x = 0;
        nx = exp_sub(rate_code);
        x_chg = (nx != exp_x);
        exp_x = nx;
      end else begin
        chk(tcount < exp_x, rate_tag(exp_x, x_chg, first_x), tcount, exp_x);
      end
    end
    prev_t = tclk_stb;
  endtask

  task automatic reset_to(input logic m, input logic [1:0] c);
    rst = 1'b1;
    mode_hi = m;
    rate_code = c;
    for (int i = 0; i < 3; i++) begin
      step();
      observe();
    end
    rst = 1'b0;
    cyc = 0; tcount = 0; prev_t = 0;
    exp_t = exp_base(m); exp_x = exp_sub(c);
    first_t = 1; first_x = 1; t_chg = 0; x_chg = 0;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        if ($urandom_range(0, 149) == 0) mode_hi = ~mode_hi;
        if ($urandom_range(0, 399) == 0) rate_code = 2'($urandom_range(0, 3));
      end
      observe();
      step();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    step();
    // R10: every select/code pairing entered through reset
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++) begin
        reset_to(1'(m), 2'(c));
        run(14 * 8 * 3 + 20, 1'b0);
      end
    // R8: directed mid-period select change
    reset_to(1'b0, 2'd3);
    run(3, 1'b0);
    mode_hi = 1'b1;
    run(60, 1'b0);
    // R9: directed mid-period code change
    reset_to(1'b1, 2'd0);
    run(30, 1'b0);
    rate_code = 2'd2;
    run(400, 1'b0);
    // mid-run reset, then random changes
    run(7, 1'b0);
    reset_to(1'b0, 2'd1);
    run(40000, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule